// File: doc/BRIEF.md
# Memory Command Parity Guard with Lockout

This block sits on the memory-card end of a 23-bit command bus. The bus carries a 22-bit payload and one parity bit. Parity is checked on every clock, including idle clocks. A single bad word puts the block into a lockout state that lasts until reset, and an active-low error output reports it.

In lockout, no new access is started on either stack. Accesses that were already started keep their entries, and their completions retire normally. Refresh commands are still passed on to the timing engine.

Accepted accesses are written into one of two four-entry in-order queues, one per stack. The DRAM timing engine is outside the block. It sees a start pulse for each accepted access and returns a per-stack done strobe when the access completes. Each done strobe retires the oldest entry of its stack. A done strobe for an empty stack raises an underflow pulse. An access to a full stack is refused and raises an overflow pulse.

Top module: `cmdParityGuard`

## Requirements
- R1: The 23-bit word `cmdBus` is checked for odd parity (XOR of all 23 bits equal to 1) on every cycle, whatever the value of `cmdValid`. A cycle with even parity drives `errN` low from the next cycle on. A command that carries bad parity is neither started nor passed on.
- R2: After a synchronous reset, `errN` is 1 and every pulse and valid output is 0. Once `errN` is low, it stays low until the next reset.
- R3: Payload bit 21 selects refresh (1) or access (0), bit 20 selects the stack, and bits 19:0 carry the address. An access with good parity, outside lockout, to a stack that is not full gives `startValid`=1 in the next cycle, with `startStack` and `startAddr` taken from the command. The access is also appended to that stack's queue.
- R4: In lockout, an access command produces no start and is not queued.
- R5: A valid refresh command with good parity gives a one-cycle `refreshGo` in the next cycle, both in lockout and outside it.
- R6: A done strobe on stack s, when that stack's queue is not empty, gives `cplValid[s]`=1 in the next cycle. `cplAddr[20*s +: 20]` then carries the oldest queued address of that stack. This also holds in lockout.
- R7: A done strobe on stack s, when that stack's queue is empty, gives `undfPulse[s]`=1 in the next cycle and leaves `cplValid[s]` at 0.
- R8: Each queue holds 4 entries. Fullness is judged on the occupancy at the start of the cycle. An access to a full stack raises `ovflPulse[s]` in the next cycle, produces no start, and leaves the queue unchanged.
- R9: A done strobe and an accepted access on the same stack in the same cycle both take effect: the head retires and the new address joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command word is meaningful this cycle |
| cmdBus | input | 23 | Bit 22 parity, bit 21 refresh flag, bit 20 stack, bits 19:0 address |
| done | input | 2 | Per-stack completion strobe from the timing engine |
| errN | output | 1 | Active-low lockout/error indication |
| startValid | output | 1 | Access start pulse to the timing engine |
| startStack | output | 1 | Stack of the started access |
| startAddr | output | 20 | Address of the started access |
| refreshGo | output | 1 | Refresh pulse to the timing engine |
| cplValid | output | 2 | Per-stack retire pulse |
| cplAddr | output | 40 | Retired address, stack s in bits 20*s+19:20*s |
| ovflPulse | output | 2 | Access refused because the stack queue is full |
| undfPulse | output | 2 | Completion arrived for an empty stack queue |

## Verification
Seeded random runs mix accesses, refreshes and completions on both stacks, and inject occasional bad-parity words, some of them on idle cycles. Comparing the outputs against a bench queue model separates correct in-order retirement from stale or reordered heads, and separates parity-driven lockout from plain command decoding. Directed sequences fill one stack to its limit and retire and push on that stack in the same cycle. They also drain a stack past empty, and, once locked, issue an access, a refresh and completions. The locked-state sequence shows that blocked accesses leave no queue entries behind while refresh and pending completions still go through.

// File: rtl/cmdGuardPkg.sv
package cmdGuardPkg;
  localparam int STACKS = 2;

  typedef struct packed {
    logic [STACKS-1:0] push;
    logic [STACKS-1:0] pop;
    logic [STACKS-1:0] ovfl;
    logic [STACKS-1:0] undf;
    logic              refreshGo;
  } guardStrobeT;
endpackage

// File: rtl/stackQueue.sv
module stackQueue #(
  parameter int W     = 20,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;

  assign head  = mem[rdPtr];
  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= din;
        wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      end
      if (pop) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: the controller never pushes into a full queue
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> (count != FULL_CNT));
  // R7: the controller never pops an empty queue
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/guardCtrl.sv
module guardCtrl
  import cmdGuardPkg::*;
#(
  parameter int PAY_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [PAY_W:0]    cmdBus,
  input  logic [STACKS-1:0] done,
  input  logic [STACKS-1:0] full,
  input  logic [STACKS-1:0] empty,
  output guardStrobeT       strb,
  output logic              locked
);
  logic parityOk, isRefresh, stackSel, accessReq;

  assign parityOk  = ^cmdBus;            // odd parity over all 23 bits
  assign isRefresh = cmdBus[PAY_W-1];
  assign stackSel  = cmdBus[PAY_W-2];
  assign accessReq = cmdValid && !isRefresh && parityOk && !locked;

  always_ff @(posedge clk) begin
    if (rst) locked <= 1'b0;
    else if (!parityOk) locked <= 1'b1;
  end

  always_comb begin
    strb = '0;
    strb.refreshGo = cmdValid && isRefresh && parityOk;
    for (int s = 0; s < STACKS; s++) begin
      strb.push[s] = accessReq && (stackSel == 1'(s)) && !full[s];
      strb.ovfl[s] = accessReq && (stackSel == 1'(s)) && full[s];
      strb.pop[s]  = done[s] && !empty[s];
      strb.undf[s] = done[s] && empty[s];
    end
  end
endmodule

// File: rtl/guardDatapath.sv
module guardDatapath
  import cmdGuardPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  guardStrobeT              strb,
  input  logic [ADDR_W-1:0]        cmdAddr,
  output logic [STACKS-1:0]        full,
  output logic [STACKS-1:0]        empty,
  output logic                     startValid,
  output logic                     startStack,
  output logic [ADDR_W-1:0]        startAddr,
  output logic                     refreshGo,
  output logic [STACKS-1:0]        cplValid,
  output logic [STACKS*ADDR_W-1:0] cplAddr,
  output logic [STACKS-1:0]        ovflPulse,
  output logic [STACKS-1:0]        undfPulse
);
  logic [ADDR_W-1:0] headAddr [STACKS];

  for (genvar s = 0; s < STACKS; s++) begin : g_stack
    stackQueue #(.W(ADDR_W), .DEPTH(DEPTH)) u_queue (
      .clk   (clk),
      .rst   (rst),
      .push  (strb.push[s]),
      .pop   (strb.pop[s]),
      .din   (cmdAddr),
      .head  (headAddr[s]),
      .full  (full[s]),
      .empty (empty[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      startValid <= 1'b0;
      startStack <= 1'b0;
      startAddr  <= '0;
      refreshGo  <= 1'b0;
      cplValid   <= '0;
      cplAddr    <= '0;
      ovflPulse  <= '0;
      undfPulse  <= '0;
    end else begin
      startValid <= |strb.push;
      startStack <= strb.push[1];
      if (|strb.push) startAddr <= cmdAddr;
      refreshGo  <= strb.refreshGo;
      cplValid   <= strb.pop;
      ovflPulse  <= strb.ovfl;
      undfPulse  <= strb.undf;
      for (int s = 0; s < STACKS; s++)
        if (strb.pop[s]) cplAddr[s*ADDR_W +: ADDR_W] <= headAddr[s];
    end
  end

  // R3: at most one stack accepts an access per cycle
  assert_single_push_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.push));
endmodule

// File: rtl/cmdParityGuard.sv
module cmdParityGuard
  import cmdGuardPkg::*;
#(
  parameter int PAY_W       = 22,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmdValid,
  input  logic [PAY_W:0]               cmdBus,
  input  logic [1:0]                   done,
  output logic                         errN,
  output logic                         startValid,
  output logic                         startStack,
  output logic [PAY_W-3:0]             startAddr,
  output logic                         refreshGo,
  output logic [1:0]                   cplValid,
  output logic [2*(PAY_W-2)-1:0]       cplAddr,
  output logic [1:0]                   ovflPulse,
  output logic [1:0]                   undfPulse
);
  localparam int ADDR_W = PAY_W - 2;

  guardStrobeT       strb;
  logic              locked;
  logic [STACKS-1:0] full, empty;

  guardCtrl #(.PAY_W(PAY_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdValid (cmdValid),
    .cmdBus   (cmdBus),
    .done     (done),
    .full     (full),
    .empty    (empty),
    .strb     (strb),
    .locked   (locked)
  );

  guardDatapath #(.ADDR_W(ADDR_W), .DEPTH(QUEUE_DEPTH)) u_data (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .cmdAddr    (cmdBus[ADDR_W-1:0]),
    .full       (full),
    .empty      (empty),
    .startValid (startValid),
    .startStack (startStack),
    .startAddr  (startAddr),
    .refreshGo  (refreshGo),
    .cplValid   (cplValid),
    .cplAddr    (cplAddr),
    .ovflPulse  (ovflPulse),
    .undfPulse  (undfPulse)
  );

  assign errN = !locked;

  // R1: an even-parity word on the bus pulls errN low in the next cycle
  assert_bad_parity_R1: assert property (@(posedge clk) disable iff (rst)
    !(^cmdBus) |=> !errN);
  // R2: errN stays low until reset
  assert_err_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !errN |=> !errN);
  // R4: no access starts out of a locked cycle
  assert_no_start_locked_R4: assert property (@(posedge clk) disable iff (rst)
    !errN |=> !startValid);
  // R5: good refresh commands pass even in lockout
  assert_refresh_passes_R5: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdBus[PAY_W-1] && (^cmdBus)) |=> refreshGo);
  // R7: an underflow and a retire never coexist on one stack
  assert_undf_excl_R7: assert property (@(posedge clk) disable iff (rst)
    (undfPulse & cplValid) == 2'b00);
endmodule

// File: tb/test_cmdParityGuard.sv
module test_cmdParityGuard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic [22:0] cmdBus = 23'h400000;
  logic [1:0]  done = 2'b00;
  logic        errN, startValid, startStack, refreshGo;
  logic [19:0] startAddr;
  logic [1:0]  cplValid, ovflPulse, undfPulse;
  logic [39:0] cplAddr;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic        mLock;
  logic [19:0] mq [2][4];
  int          mCnt [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdParityGuard i_cmdParityGuard (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdBus(cmdBus), .done(done),
    .errN(errN), .startValid(startValid), .startStack(startStack),
    .startAddr(startAddr), .refreshGo(refreshGo), .cplValid(cplValid),
    .cplAddr(cplAddr), .ovflPulse(ovflPulse), .undfPulse(undfPulse)
  );

  function automatic logic [22:0] mkCmd(input bit isRef, input bit st,
                                        input logic [19:0] a, input bit bad);
    logic [21:0] pl;
    pl = {isRef, st, a};
    return {(~^pl) ^ bad, pl};
  endfunction

  task automatic chk(input logic [39:0] act, input logic [39:0] exp,
                     input string req, input string what, input string ctx);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s [%s]: actual=%0h expected=%0h", req, what, ctx, act, exp);
    end
  endtask

  task automatic doReset(input string ctx);
    rst = 1'b1; cmdValid = 1'b0; cmdBus = mkCmd(0, 0, 20'h0, 0); done = 2'b00;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mLock = 1'b0; mCnt[0] = 0; mCnt[1] = 0;
    chk(errN, 1, "R2", "errN after reset", ctx);
    chk({startValid, refreshGo, cplValid, ovflPulse, undfPulse}, 0, "R2", "pulses after reset", ctx);
  endtask

  task automatic step(input logic v, input logic [22:0] bus, input logic [1:0] dn,
                      input string ctx);
    logic pOk, isRef, st, expStart, expRef;
    logic [1:0] expCpl, expOv, expUn;
    logic [19:0] expCa [2];
    cmdValid = v; cmdBus = bus; done = dn;
    pOk = ^bus; isRef = bus[21]; st = bus[20];
    expCpl = 0; expOv = 0; expUn = 0; expCa[0] = 0; expCa[1] = 0;
    expStart = v && !isRef && pOk && !mLock && (mCnt[st] < 4);
    expOv[st] = v && !isRef && pOk && !mLock && (mCnt[st] == 4);
    expRef = v && isRef && pOk;
    for (int s = 0; s < 2; s++) begin
      if (dn[s]) begin
        if (mCnt[s] > 0) begin
          expCpl[s] = 1'b1; expCa[s] = mq[s][0];
          for (int k = 0; k < 3; k++) mq[s][k] = mq[s][k+1];
          mCnt[s]--;
        end else expUn[s] = 1'b1;
      end
    end
    if (expStart) begin mq[st][mCnt[st]] = bus[19:0]; mCnt[st]++; end
    mLock = mLock | !pOk;
    @(negedge clk);
    chk(errN, !mLock, "R1/R2", "errN", ctx);
    chk(startValid, expStart, "R3/R4", "startValid", ctx);
    if (expStart) chk({startStack, startAddr}, {st, bus[19:0]}, "R3", "start stack/addr", ctx);
    chk(refreshGo, expRef, "R5", "refreshGo", ctx);
    chk(cplValid, expCpl, "R6", "cplValid", ctx);
    for (int s = 0; s < 2; s++)
      if (expCpl[s]) chk(cplAddr[s*20 +: 20], expCa[s], "R6", "cplAddr", ctx);
    chk(undfPulse, expUn, "R7", "undfPulse", ctx);
    chk(ovflPulse, expOv, "R8", "ovflPulse", ctx);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    doReset("R2 initial");
    // R3 fill stack 0, R8 overflow on the fifth access
    for (int i = 0; i < 4; i++) step(1, mkCmd(0, 0, 20'h100 + 20'(i), 0), 2'b00, "R3 fill");
    step(1, mkCmd(0, 0, 20'hBAD00, 0), 2'b00, "R8 full refuse");
    step(0, mkCmd(0, 0, 0, 0), 2'b01, "R6 retire head");
    // R9 retire and push on the same stack in one cycle
    step(1, mkCmd(0, 0, 20'h777, 0), 2'b01, "R9 push+pop");
    for (int i = 0; i < 3; i++) step(0, mkCmd(0, 0, 0, 0), 2'b01, "R6 drain");
    step(0, mkCmd(0, 0, 0, 0), 2'b01, "R7 empty done");
    step(0, mkCmd(0, 0, 0, 0), 2'b11, "R7 both empty");
    // lockout sequence
    step(1, mkCmd(0, 1, 20'hA1, 0), 2'b00, "R3 stack1");
    step(1, mkCmd(0, 1, 20'hA2, 0), 2'b00, "R3 stack1");
    step(0, mkCmd(0, 0, 20'h5, 1), 2'b00, "R1 idle bad parity");
    step(1, mkCmd(0, 1, 20'hA3, 0), 2'b00, "R4 access locked");
    step(1, mkCmd(1, 0, 20'h0, 0), 2'b00, "R5 refresh locked");
    step(0, mkCmd(0, 0, 0, 0), 2'b10, "R6 retire locked");
    step(0, mkCmd(0, 0, 0, 0), 2'b10, "R6 retire locked");
    step(0, mkCmd(0, 0, 0, 0), 2'b10, "R4 nothing queued");
    for (int i = 0; i < 5; i++) step(0, mkCmd(0, 0, 0, 0), 2'b00, "R2 sticky");
    doReset("R2 reset clears lock");
    step(1, mkCmd(0, 0, 20'h33, 1), 2'b00, "R1 bad access");
    step(1, mkCmd(1, 0, 20'h0, 1), 2'b00, "R1 bad refresh");
    // seeded random phases
    for (int ph = 0; ph < 6; ph++) begin
      doReset("R2 phase");
      for (int c = 0; c < 400; c++) begin
        bit v, r, st, bad;
        v = ($urandom_range(0, 9) < 6);
        r = ($urandom_range(0, 4) == 0);
        st = 1'($urandom_range(0, 1));
        bad = ($urandom_range(0, 199) == 0);
        step(v, mkCmd(r, st, 20'($urandom), bad), 2'($urandom) & 2'($urandom), "random");
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule